// File: doc/BRIEF.md
# Condition Code Evaluator And Select

This unit takes the four status flags of an integer datapath (zero, negative, overflow, carry) and a 4-bit condition code, and decides whether that condition holds. The code is given as a 3-bit condition field and a separate invert bit, the way an instruction word carries them. The unit joins them into one code with the invert bit as the least significant bit. The sixteen codes cover constant true and false, the single-flag tests, and the unsigned and signed comparisons.

A single boolean outcome feeds three consumers at once. The first is a branch-taken bit. The second is a set-on-condition word that is 1 or 0, zero-extended to the data width. The third is a select word that passes the first operand when the condition holds and the second operand when it does not. All three results, and a valid flag, leave the unit through one register stage. An accepted request appears on the outputs on the next clock edge. When no request is presented, the outputs hold their last values and the valid flag is low.

Top module: `cond_eval_select`

## Requirements
- R1: The condition code is {cond_field[2:0], cond_inv}, with cond_inv as bit 0. For every field value, setting cond_inv gives the complement of the outcome the same field gives with cond_inv clear.
- R2: Code 0000 always holds, and code 0001 never holds, whatever the flags are.
- R3: Code 0010 holds when C=1 and Z=0 (unsigned higher). Code 0011 holds when C=0 or Z=1 (unsigned lower-or-same).
- R4: Codes 0100 and 0101 hold for C=0 and for C=1. Codes 0110 and 0111 hold for Z=0 and for Z=1.
- R5: Codes 1000 and 1001 hold for V=0 and for V=1. Codes 1010 and 1011 hold for N=0 and for N=1.
- R6: Code 1100 holds when N equals V (signed greater-or-equal). Code 1101 holds when N differs from V (signed less-than).
- R7: Code 1110 holds when N equals V and Z=0 (signed greater-than). Code 1111 holds when Z=1 or N differs from V (signed less-or-equal).
- R8: sel_word equals op_a when the condition holds and op_b otherwise.
- R9: set_word is 32'h00000001 when the condition holds and 32'h00000000 otherwise, and its bit 0 always matches taken.
- R10: A request with in_valid high at a rising edge appears on taken, set_word and sel_word, with out_valid high, after that edge. After an edge where in_valid is low, out_valid is low and the three results keep their previous values.
- R11: While rst_n is low, out_valid, taken, set_word and sel_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| cond_field | input | 3 | Upper three bits of the condition code |
| cond_inv | input | 1 | Invert bit, least significant bit of the code |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| op_a | input | 32 | Operand passed when the condition holds |
| op_b | input | 32 | Operand passed when the condition fails |
| out_valid | output | 1 | Registered results are new this cycle |
| taken | output | 1 | Registered condition outcome (branch taken) |
| set_word | output | 32 | Registered set-on-condition word |
| sel_word | output | 32 | Registered select result |

## Verification
A wrong base condition, a swapped field-to-code mapping or an inverted invert bit changes taken, set_word and sel_word together, one edge after the request. The bench therefore tests every code against flag patterns that separate it from its neighbours. A stale or wrongly cleared result register shows up on the first idle cycle, when out_valid must fall and the results must keep their previous values. A broken zero-extension or a swapped select shows up on the same cycle as the outcome. The test operands are chosen random and distinct, so a wrong choice between them cannot go unseen.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

   localparam int CCS_FIELD_W = 3;
   localparam int CCS_CODE_W  = CCS_FIELD_W + 1;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
      logic c;
   } ccs_flags_t;

   // Base tests, one per field value; the invert bit complements them.
   typedef enum logic [CCS_FIELD_W-1:0] {
      CF_ALWAYS = 3'd0,
      CF_UHI    = 3'd1,
      CF_CCLR   = 3'd2,
      CF_ZCLR   = 3'd3,
      CF_VCLR   = 3'd4,
      CF_NCLR   = 3'd5,
      CF_SGE    = 3'd6,
      CF_SGT    = 3'd7
   } ccs_field_e;

   function automatic logic [CCS_CODE_W-1:0] ccs_join_code(
      input logic [CCS_FIELD_W-1:0] field,
      input logic                   inv
   );
      return {field, inv};
   endfunction

endpackage

// File: rtl/ccs_cond_eval.sv
module ccs_cond_eval
   import ccs_pkg::*;
#(
   parameter bit FLAT_DECODE = 1'b0
) (
   input  logic [CCS_CODE_W-1:0] code,
   input  ccs_flags_t            flags,
   output logic                  holds
);

   logic n_eq_v;
   assign n_eq_v = (flags.n == flags.v);

   generate
      if (FLAT_DECODE) begin : g_flat
         // All sixteen outcomes are decoded directly from the 4-bit code.
         always_comb begin
            unique case (code)
               4'b0000: holds = 1'b1;
               4'b0001: holds = 1'b0;
               4'b0010: holds = flags.c & ~flags.z;
               4'b0011: holds = ~flags.c | flags.z;
               4'b0100: holds = ~flags.c;
               4'b0101: holds = flags.c;
               4'b0110: holds = ~flags.z;
               4'b0111: holds = flags.z;
               4'b1000: holds = ~flags.v;
               4'b1001: holds = flags.v;
               4'b1010: holds = ~flags.n;
               4'b1011: holds = flags.n;
               4'b1100: holds = n_eq_v;
               4'b1101: holds = ~n_eq_v;
               4'b1110: holds = n_eq_v & ~flags.z;
               default: holds = ~n_eq_v | flags.z;
            endcase
         end
      end else begin : g_base_inv
         // Eight base tests picked by the field, then one XOR by the invert bit.
         logic base;
         always_comb begin
            unique case (code[CCS_CODE_W-1:1])
               CF_ALWAYS: base = 1'b1;
               CF_UHI:    base = flags.c & ~flags.z;
               CF_CCLR:   base = ~flags.c;
               CF_ZCLR:   base = ~flags.z;
               CF_VCLR:   base = ~flags.v;
               CF_NCLR:   base = ~flags.n;
               CF_SGE:    base = n_eq_v;
               default:   base = n_eq_v & ~flags.z;
            endcase
         end
         assign holds = base ^ code[0];
      end
   endgenerate

endmodule

// File: rtl/ccs_result_mux.sv
module ccs_result_mux #(
   parameter int DATA_W = 32
) (
   input  logic              holds,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] set_word,
   output logic [DATA_W-1:0] sel_word
);

   localparam int PAD_W = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ccs_result_mux: DATA_W must be at least 2");
      end
   endgenerate

   assign set_word = {{PAD_W{1'b0}}, holds};
   assign sel_word = holds ? op_a : op_b;

endmodule

// File: rtl/ccs_out_stage.sv
module ccs_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              holds,
   input  logic [DATA_W-1:0] set_word,
   input  logic [DATA_W-1:0] sel_word,
   output logic              valid_q,
   output logic              taken_q,
   output logic [DATA_W-1:0] set_q,
   output logic [DATA_W-1:0] sel_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         taken_q <= 1'b0;
         set_q   <= '0;
         sel_q   <= '0;
      end else begin
         valid_q <= load;
         if (load) begin
            taken_q <= holds;
            set_q   <= set_word;
            sel_q   <= sel_word;
         end
      end
   end

   // R10: one-cycle latency of the valid flag
   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> valid_q);
   p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !valid_q);
   // R10: results hold while idle
   p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(taken_q) && $stable(set_q) && $stable(sel_q)));

endmodule

// File: rtl/cond_eval_select.sv
module cond_eval_select
   import ccs_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit FLAT_DECODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        cond_field,
   input  logic              cond_inv,
   input  logic              flag_z,
   input  logic              flag_n,
   input  logic              flag_v,
   input  logic              flag_c,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_valid,
   output logic              taken,
   output logic [DATA_W-1:0] set_word,
   output logic [DATA_W-1:0] sel_word
);

   logic [CCS_CODE_W-1:0] code;
   ccs_flags_t            flags;
   logic                  holds;
   logic [DATA_W-1:0]     set_d;
   logic [DATA_W-1:0]     sel_d;

   assign code  = ccs_join_code(cond_field, cond_inv);
   assign flags = '{z: flag_z, n: flag_n, v: flag_v, c: flag_c};

   ccs_cond_eval #(
      .FLAT_DECODE(FLAT_DECODE)
   ) u_eval (
      .code  (code),
      .flags (flags),
      .holds (holds)
   );

   ccs_result_mux #(
      .DATA_W(DATA_W)
   ) u_mux (
      .holds    (holds),
      .op_a     (op_a),
      .op_b     (op_b),
      .set_word (set_d),
      .sel_word (sel_d)
   );

   ccs_out_stage #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (in_valid),
      .holds    (holds),
      .set_word (set_d),
      .sel_word (sel_d),
      .valid_q  (out_valid),
      .taken_q  (taken),
      .set_q    (set_word),
      .sel_q    (sel_word)
   );

   // R9: set word is the zero-extended outcome
   p_set_zero_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (set_word[DATA_W-1:1] == '0 && set_word[0] == taken));
   // R8: select follows the registered outcome
   p_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (sel_word == (taken ? $past(op_a) : $past(op_b))));
   // R2: constant codes
   p_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_field == 3'd0) |=> (taken == !$past(cond_inv)));
   // R4: equal test
   p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_field == 3'd3 && cond_inv) |=> (taken == $past(flag_z)));
   // R6: signed greater-or-equal
   p_sge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_field == 3'd6 && !cond_inv) |=>
         (taken == ($past(flag_n) == $past(flag_v))));
   // R7: signed less-or-equal
   p_sle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_field == 3'd7 && cond_inv) |=>
         (taken == ($past(flag_z) || ($past(flag_n) != $past(flag_v)))));

endmodule

// File: tb/tb_cond_eval_select.sv
module tb_cond_eval_select;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  cond_field = '0;
   logic        cond_inv = 1'b0;
   logic        flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        out_valid, taken;
   logic [31:0] set_word, sel_word;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   cond_eval_select dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cond_field(cond_field), .cond_inv(cond_inv),
      .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
      .op_a(op_a), .op_b(op_b),
      .out_valid(out_valid), .taken(taken),
      .set_word(set_word), .sel_word(sel_word)
   );

   // Reference outcome written from the condition table.
   function automatic logic ref_cond(input logic [3:0] code,
                                     input logic z, n, v, c);
      case (code)
         4'd0:  return 1'b1;
         4'd1:  return 1'b0;
         4'd2:  return c && !z;
         4'd3:  return !c || z;
         4'd4:  return !c;
         4'd5:  return c;
         4'd6:  return !z;
         4'd7:  return z;
         4'd8:  return !v;
         4'd9:  return v;
         4'd10: return !n;
         4'd11: return n;
         4'd12: return n == v;
         4'd13: return n != v;
         4'd14: return (n == v) && !z;
         default: return z || (n != v);
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] code);
      case (code)
         4'd0, 4'd1:   return "R2";
         4'd2, 4'd3:   return "R3";
         4'd4, 4'd5, 4'd6, 4'd7: return "R4";
         4'd8, 4'd9, 4'd10, 4'd11: return "R5";
         4'd12, 4'd13: return "R6";
         default:      return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one request at a falling edge and check the registered results
   // at the next falling edge.
   task automatic run_vec(input logic [2:0] f, input logic inv,
                          input logic z, n, v, c,
                          input logic [31:0] a, b, input string extra_tag);
      logic [3:0] code;
      logic       exp;
      code = {f, inv};
      exp  = ref_cond(code, z, n, v, c);
      in_valid = 1'b1; cond_field = f; cond_inv = inv;
      flag_z = z; flag_n = n; flag_v = v; flag_c = c;
      op_a = a; op_b = b;
      @(negedge clk);
      chk("R10 out_valid", {31'b0, out_valid}, 32'd1);
      chk(tag_of(code), {31'b0, taken}, {31'b0, exp});
      if (extra_tag.len() != 0) chk(extra_tag, {31'b0, taken}, {31'b0, exp});
      chk("R9 set_word", set_word, {31'b0, exp});
      chk("R8 sel_word", sel_word, exp ? a : b);
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] last_sel, last_set;
      logic        last_taken;
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
      chk("R11 taken", {31'b0, taken}, 32'd0);
      chk("R11 set_word", set_word, 32'd0);
      chk("R11 sel_word", sel_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: every code against all sixteen flag patterns.
      for (int cd = 0; cd < 16; cd++) begin
         for (int fl = 0; fl < 16; fl++) begin
            logic [3:0] cv;
            logic [3:0] fv;
            cv = 4'(cd);
            fv = 4'(fl);
            run_vec(cv[3:1], cv[0], fv[3], fv[2], fv[1], fv[0],
                    32'hA5A5_0000 + 32'(cd), 32'h5A5A_0000 + 32'(fl), "");
         end
      end

      // R1: same field, invert bit flips the outcome (C=1, Z=0 on field 1).
      run_vec(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1111_1111, 32'h2222_2222, "R1");
      run_vec(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1111_1111, 32'h2222_2222, "R1");
      // R1: invert bit lands in bit 0 (field 6 vs field 3 would differ).
      run_vec(3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hFEED_F00D, "R1");

      // R10: idle cycle clears valid and holds results while inputs change.
      last_taken = taken; last_set = set_word; last_sel = sel_word;
      in_valid = 1'b0;
      cond_field = ~cond_field; cond_inv = ~cond_inv;
      flag_z = ~flag_z; flag_n = ~flag_n; op_a = 32'h0; op_b = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R10 idle out_valid", {31'b0, out_valid}, 32'd0);
      chk("R10 idle taken", {31'b0, taken}, {31'b0, last_taken});
      chk("R10 idle set_word", set_word, last_set);
      chk("R10 idle sel_word", sel_word, last_sel);

      // Random requests mixed with idle gaps.
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[31:29] == 3'd0) begin
            last_taken = taken; last_set = set_word; last_sel = sel_word;
            in_valid = 1'b0;
            op_a = $urandom; op_b = $urandom; cond_field = r[2:0];
            @(negedge clk);
            chk("R10 gap out_valid", {31'b0, out_valid}, 32'd0);
            chk("R10 gap sel_word", sel_word, last_sel);
            chk("R10 gap taken", {31'b0, taken}, {31'b0, last_taken});
         end else begin
            run_vec(r[2:0], r[3], r[4], r[5], r[6], r[7],
                    $urandom, $urandom, "");
         end
      end

      // R11: reset in mid-run clears outputs.
      rst_n = 1'b0;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R11 rerun out_valid", {31'b0, out_valid}, 32'd0);
      chk("R11 rerun sel_word", sel_word, 32'd0);
      chk("R11 rerun set_word", set_word, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule